// File: doc/BRIEF.md
# Programmable-Delay Implication Checker

This block is a synthesizable runtime monitor for one temporal rule. An attempt begins when `sig_a` rises. The block samples `sig_b` a programmable number of cycles later (delay one). If `sig_b` is high at that point, it samples `sig_c` a second programmable number of cycles later (delay two). The attempt passes when `sig_c` is high and fails when it is low. If `sig_b` was low, the attempt ends vacuously and reports no error.

Both delays live in a small configuration register pair that software writes at run time. Each attempt takes a private copy of the delays on the cycle it starts. Attempts that start on different cycles overlap freely, and each one runs in its own slot of a fixed pool. On every cycle the outputs give the number of attempts that passed, failed and ended vacuously, so results that land on the same cycle are all reported. When the pool is full, a new attempt is dropped and a sticky overflow flag is raised.

The rule is sampled on rising clock edges. All signals are plain control pins with no handshake, because nothing flows through the block that could apply back-pressure.

Top module: `chk_dly_impl`

## Requirements
- R1: An attempt starts on each rising clock edge where `sig_a` is 1 and was 0 at the previous edge. After reset the previous value counts as 0.
- R2: For an attempt started at edge t with delay one equal to D1, `sig_b` is sampled at edge t+D1, and D1 = 0 means edge t itself. If `sig_b` is 0 there, the attempt ends vacuously.
- R3: If `sig_b` was 1, `sig_c` is sampled D2 edges later, and D2 = 0 means the same edge. The attempt passes if `sig_c` is 1 and fails if it is 0, then retires.
- R4: A result decided at edge e shows in `pass_cnt`, `fail_cnt` or `vac_cnt` from just after edge e until edge e+1 only. Otherwise those outputs are 0.
- R5: An attempt uses the delay register values held at its start edge. A write on that same edge or on any later edge does not change the attempt's timing.
- R6: After reset, delay one is 2 and delay two is 7. A write with `cfg_we` = 1 loads `cfg_d1` and `cfg_d2` at the edge.
- R7: Attempts run independently. When several attempts resolve on the same edge, each output carries the count of attempts with that result.
- R8: If an attempt needs a slot while all `SLOTS` slots are busy, the attempt is dropped and never produces a result, and `overflow` goes to 1 and stays 1 until reset.
- R9: While reset is active and right after it, all counts are 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_a | input | 1 | Trigger signal; a rise starts an attempt |
| sig_b | input | 1 | Antecedent end signal, sampled after delay one |
| sig_c | input | 1 | Consequent signal, sampled after delay two |
| cfg_we | input | 1 | Load enable for the delay registers |
| cfg_d1 | input | DW | New value for delay one |
| cfg_d2 | input | DW | New value for delay two |
| pass_cnt | output | CW | Number of attempts that passed at the last edge |
| fail_cnt | output | CW | Number of attempts that failed at the last edge |
| vac_cnt | output | CW | Number of attempts that ended vacuously at the last edge |
| overflow | output | 1 | Sticky flag: an attempt was dropped because the pool was full |

## Verification
The assertions assume that `sig_b` and `sig_c` are settled to 0 or 1 at each rising edge. On that basis, any nonzero count must match the value that the deciding input had one edge before the count appears. They also assume that results on one edge can never exceed one result per slot plus the one immediate result from a new start. The bench changes every input only on the falling clock edge, keeps the delays within `DW` bits, and reads the outputs at the next falling edge. Every sampled value is therefore stable and belongs to exactly one edge.

// File: rtl/chk_dly_pkg.sv
package chk_dly_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ANTE = 2'd1,
    PH_CONS = 2'd2
  } phase_t;
endpackage

// File: rtl/chk_dly_regs.sv
module chk_dly_regs #(
  parameter int DW     = 8,
  parameter int RST_D1 = 2,
  parameter int RST_D2 = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wd1,
  input  logic [DW-1:0] wd2,
  output logic [DW-1:0] d1,
  output logic [DW-1:0] d2
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= DW'(RST_D1);
      d2 <= DW'(RST_D2);
    end else if (we) begin
      d1 <= wd1;
      d2 <= wd2;
    end
  end
endmodule

// File: rtl/chk_alloc.sv
module chk_alloc #(
  parameter int N = 16
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         any_free
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = ~busy[i] & ~taken[i];
    assign taken[i+1] = taken[i] | ~busy[i];
  end
  assign any_free = taken[N];
endmodule

// File: rtl/chk_slot.sv
module chk_slot
  import chk_dly_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_cons,
  input  logic [DW-1:0] load_ctr,
  input  logic [DW-1:0] load_d2,
  input  logic          smp_b,
  input  logic          smp_c,
  output logic          busy,
  output logic          hit_pass,
  output logic          hit_fail,
  output logic          hit_vac
);
  phase_t        phase_q;
  logic [DW-1:0] ctr_q;
  logic [DW-1:0] d2_q;
  logic          due;

  assign busy = (phase_q != PH_IDLE);
  assign due  = busy && (ctr_q == DW'(1));

  always_comb begin
    hit_pass = 1'b0;
    hit_fail = 1'b0;
    hit_vac  = 1'b0;
    if (due) begin
      if (phase_q == PH_ANTE) begin
        if (!smp_b) begin
          hit_vac = 1'b1;
        end else if (d2_q == '0) begin
          hit_pass = smp_c;
          hit_fail = ~smp_c;
        end
      end else begin
        hit_pass = smp_c;
        hit_fail = ~smp_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ctr_q   <= '0;
      d2_q    <= '0;
    end else if (load) begin
      phase_q <= load_cons ? PH_CONS : PH_ANTE;
      ctr_q   <= load_ctr;
      d2_q    <= load_d2;
    end else if (busy) begin
      if (due) begin
        if ((phase_q == PH_ANTE) && smp_b && (d2_q != '0)) begin
          phase_q <= PH_CONS;
          ctr_q   <= d2_q;
        end else begin
          phase_q <= PH_IDLE;
        end
      end else begin
        ctr_q <= ctr_q - DW'(1);
      end
    end
  end
endmodule

// File: rtl/chk_dly_impl.sv
module chk_dly_impl #(
  parameter int SLOTS  = 16,
  parameter int DW     = 8,
  parameter int RST_D1 = 2,
  parameter int RST_D2 = 7,
  localparam int CW    = $clog2(SLOTS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_a,
  input  logic          sig_b,
  input  logic          sig_c,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_d1,
  input  logic [DW-1:0] cfg_d2,
  output logic [CW-1:0] pass_cnt,
  output logic [CW-1:0] fail_cnt,
  output logic [CW-1:0] vac_cnt,
  output logic          overflow
);
  logic [DW-1:0]    d1_q, d2_q;
  logic             a_prev;
  logic             start, z1, need_slot;
  logic             imm_pass, imm_fail, imm_vac;
  logic [SLOTS-1:0] busy, grant, load;
  logic [SLOTS-1:0] s_pass, s_fail, s_vac;
  logic             any_free;
  logic [DW-1:0]    load_ctr;
  logic [CW-1:0]    sum_p, sum_f, sum_v;

  chk_dly_regs #(.DW(DW), .RST_D1(RST_D1), .RST_D2(RST_D2)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wd1(cfg_d1), .wd2(cfg_d2),
    .d1(d1_q), .d2(d2_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) a_prev <= 1'b0;
    else        a_prev <= sig_a;
  end

  assign start     = sig_a & ~a_prev;
  assign z1        = (d1_q == '0);
  assign imm_vac   = start & z1 & ~sig_b;
  assign imm_pass  = start & z1 & sig_b & (d2_q == '0) & sig_c;
  assign imm_fail  = start & z1 & sig_b & (d2_q == '0) & ~sig_c;
  assign need_slot = start & ~(z1 & (~sig_b | (d2_q == '0)));
  assign load_ctr  = z1 ? d2_q : d1_q;
  assign load      = grant & {SLOTS{need_slot}};

  chk_alloc #(.N(SLOTS)) u_alloc (
    .busy(busy), .grant(grant), .any_free(any_free)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    chk_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load[i]), .load_cons(z1), .load_ctr(load_ctr), .load_d2(d2_q),
      .smp_b(sig_b), .smp_c(sig_c),
      .busy(busy[i]), .hit_pass(s_pass[i]), .hit_fail(s_fail[i]),
      .hit_vac(s_vac[i])
    );
  end

  always_comb begin
    sum_p = CW'(imm_pass);
    sum_f = CW'(imm_fail);
    sum_v = CW'(imm_vac);
    for (int i = 0; i < SLOTS; i++) begin
      sum_p = sum_p + CW'(s_pass[i]);
      sum_f = sum_f + CW'(s_fail[i]);
      sum_v = sum_v + CW'(s_vac[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_cnt <= '0;
      fail_cnt <= '0;
      vac_cnt  <= '0;
      overflow <= 1'b0;
    end else begin
      pass_cnt <= sum_p;
      fail_cnt <= sum_f;
      vac_cnt  <= sum_v;
      if (need_slot && !any_free) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/chk_dly_impl_sva.sv
module chk_dly_impl_sva #(
  parameter int SLOTS = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(SLOTS + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sig_a,
  input logic          sig_b,
  input logic          sig_c,
  input logic          cfg_we,
  input logic [DW-1:0] cfg_d1,
  input logic [DW-1:0] cfg_d2,
  input logic [CW-1:0] pass_cnt,
  input logic [CW-1:0] fail_cnt,
  input logic [CW-1:0] vac_cnt,
  input logic          overflow
);
  AST_PASS_SAW_C: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_cnt != '0) |-> $past(sig_c));  // R3
  AST_FAIL_SAW_NO_C: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt != '0) |-> !$past(sig_c));  // R3
  AST_VAC_SAW_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (vac_cnt != '0) |-> !$past(sig_b));  // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R8
  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pass_cnt) + 32'(fail_cnt) + 32'(vac_cnt)) <= SLOTS + 1);  // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (pass_cnt == '0) && (fail_cnt == '0) && (vac_cnt == '0) && !overflow);  // R9
endmodule

bind chk_dly_impl chk_dly_impl_sva #(.SLOTS(SLOTS), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
  .cfg_we(cfg_we), .cfg_d1(cfg_d1), .cfg_d2(cfg_d2),
  .pass_cnt(pass_cnt), .fail_cnt(fail_cnt), .vac_cnt(vac_cnt),
  .overflow(overflow)
);

// File: tb/chk_dly_impl_tb.sv
`timescale 1ns/1ps
module chk_dly_impl_tb;
  localparam int SLOTS = 16;
  localparam int DW    = 8;
  localparam int CW    = $clog2(SLOTS + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_a = 1'b0, sig_b = 1'b0, sig_c = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] cfg_d1 = '0, cfg_d2 = '0;
  logic [CW-1:0] pass_cnt, fail_cnt, vac_cnt;
  logic overflow;

  int n_chk = 0, n_bad = 0;
  int tp, tf, tv, fp, ff, fv, kc;
  int op, of, ov;
  logic oo;

  always #2 clk = ~clk;

  chk_dly_impl #(.SLOTS(SLOTS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
    .cfg_we(cfg_we), .cfg_d1(cfg_d1), .cfg_d2(cfg_d2),
    .pass_cnt(pass_cnt), .fail_cnt(fail_cnt), .vac_cnt(vac_cnt),
    .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    tp = 0; tf = 0; tv = 0; fp = -1; ff = -1; fv = -1; kc = 0;
  endtask

  // drive at falling edge, let one rising edge pass, read at next falling edge
  task automatic cyc(input logic ia, ib, ic, input logic iwe = 1'b0,
                     input int w1 = 0, input int w2 = 0);
    sig_a = ia; sig_b = ib; sig_c = ic;
    cfg_we = iwe; cfg_d1 = DW'(w1); cfg_d2 = DW'(w2);
    @(posedge clk);
    @(negedge clk);
    op = int'(pass_cnt); of = int'(fail_cnt); ov = int'(vac_cnt); oo = overflow;
    tp += op; tf += of; tv += ov;
    if (op != 0 && fp < 0) fp = kc;
    if (of != 0 && ff < 0) ff = kc;
    if (ov != 0 && fv < 0) fv = kc;
    kc++;
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    check("R9 pass_cnt in reset", op, 0);
    check("R9 overflow in reset", int'(oo), 0);
    rst_n = 1'b1;
    clr();
    idle(2);
    check("R9 counts after reset", tp + tf + tv, 0);
    check("R9 overflow after reset", int'(oo), 0);
  endtask

  task automatic t_default_pass();
    clr();
    for (int k = 0; k < 12; k++) cyc(k == 0, k == 2, k == 9);
    check("R6 R3 default delays pass total", tp, 1);
    check("R4 pass appears once at cycle 9", fp, 9);
    check("R3 no fail", tf, 0);
    check("R2 no vacuous", tv, 0);
  endtask

  task automatic t_default_fail();
    clr();
    for (int k = 0; k < 12; k++) cyc(k == 0, k == 2, 1'b0);
    check("R3 fail total", tf, 1);
    check("R3 fail cycle", ff, 9);
    check("R3 no pass on fail", tp, 0);
  endtask

  task automatic t_vacuous();
    clr();
    for (int k = 0; k < 12; k++) cyc(k == 0, 1'b0, 1'b1);
    check("R2 vacuous total", tv, 1);
    check("R2 vacuous cycle", fv, 2);
    check("R2 vacuous gives no pass", tp + tf, 0);
  endtask

  task automatic t_rise_only();
    // a held high for several cycles is one rise only
    clr();
    for (int k = 0; k < 14; k++) cyc(k < 5, 1'b1, 1'b1);
    check("R1 held high gives one attempt", tp, 1);
    check("R1 held high pass cycle", fp, 9);
  endtask

  task automatic t_zero_delays();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
    clr();
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    check("R2 R3 zero delays same-cycle pass", fp, 0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R2 zero delay vacuous cycle", fv, 2);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0, 3);
    clr();
    for (int k = 0; k < 6; k++) cyc(k == 0, k == 0, k == 3);
    check("R3 zero D1 then D2=3 pass cycle", fp, 3);
    check("R3 zero D1 then D2=3 pass total", tp, 1);
  endtask

  task automatic t_capture();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 3, 4);
    clr();
    for (int k = 0; k < 10; k++)
      cyc(k == 0, k == 3, k == 7, k == 1, 1, 1);
    check("R5 captured delays pass cycle", fp, 7);
    check("R5 later write ignored no vacuous", tv, 0);
    check("R5 later write ignored pass total", tp, 1);
  endtask

  task automatic t_overlap();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2, 2);
    clr();
    for (int k = 0; k < 8; k++) cyc(k == 0 || k == 2, k == 2 || k == 4, k == 4);
    check("R7 first attempt pass cycle", fp, 4);
    check("R7 second attempt fail cycle", ff, 6);
    check("R7 overlap totals", tp * 10 + tf, 11);
    // two attempts resolving on one edge, write on start edge ignored
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1, 4);
    clr();
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 2, 1);
    for (int k = 1; k < 8; k++) cyc(k == 2, k == 1 || k == 4, k == 5);
    check("R7 coincident pass cycle", fp, 5);
    check("R7 R5 coincident pass count", tp, 2);
  endtask

  task automatic t_overflow();
    int ovf_before, ovf_after;
    ovf_before = -1; ovf_after = -1;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 60, 0);
    clr();
    for (int k = 0; k < 96; k++) begin
      cyc((k % 2 == 0) && (k <= 32), 1'b0, 1'b0);
      if (k == 30) ovf_before = int'(oo);
      if (k == 32) ovf_after = int'(oo);
    end
    check("R8 no overflow with free slot", ovf_before, 0);
    check("R8 overflow when pool full", ovf_after, 1);
    check("R8 dropped attempt gives no result", tv, 16);
    check("R8 first result cycle", fv, 60);
    check("R8 overflow sticky", int'(oo), 1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_default_pass();
    t_default_fail();
    t_vacuous();
    t_rise_only();
    t_zero_delays();
    t_capture();
    t_overlap();
    t_overflow();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule